// File: doc/BRIEF.md
# Serial and Pin Gated Eight-Channel Switch Controller

This block is the digital control core of an eight-channel low-side output driver. A host writes commands over a SPI slave port. The port takes frames of 8 or 16 bits, most significant bit first. The block latches the last eight bits received when chip select is released.

Channels 0 to 5 switch on only when their latched command bit and their parallel pin are both high. Channels 6 and 7 follow their pins alone. The two top command bits do not drive channels: they appear as open-load detection enables for the six serial-controlled channels. While a frame is being clocked in, the eight channel fault flags shift out on the serial output, starting with channel 7.

A limp-home input forces a fixed mapping. Pins 0 to 5 drive channels 0 to 5 directly, channels 6 and 7 are held off, and the serial output is released. Frames are still received and latched in this mode. All SPI inputs pass through two-flop synchronizers and are handled in the system clock domain.

Top module: `oct_switch_ctrl`

## Requirements
- R1: After reset the command latch is zero: gate[5:0] is 0, ol_en is 0, and so_en is 0 while cs_n is high.
- R2: A frame of exactly 8 SCLK rising edges is sampled from si, first bit as bit 7, and is latched when cs_n rises. Bits 5..0 enable channels 5..0. Bits 7..6 appear on ol_en[1:0].
- R3: A frame of exactly 16 bits latches only its last eight bits received.
- R4: A frame with any other bit count (0, 7, 9, ...) is discarded, and the previous command stays in effect.
- R5: With mode low, gate[i] = cmd[i] & par_in[i] for i in 0..5, and gate[7:6] = par_in[7:6].
- R6: With mode high, gate[5:0] = par_in[5:0] and gate[7:6] = 0, whatever the command.
- R7: Frames sent while mode is high are still latched and take effect once mode is low.
- R8: so_en is high only while cs_n is low and mode is low.
- R9: fault[7:0] is captured when cs_n falls. so_d shows fault[7] before any SCLK edge and advances one bit, toward fault[0], on each falling SCLK. Bits 9 to 16 of a frame read 0.
- R10: A change on fault after cs_n has fallen does not alter the bits returned in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI bit clock, low when cs_n falls |
| si | input | 1 | SPI serial data in |
| mode | input | 1 | Limp-home override, active high |
| par_in | input | 8 | Parallel channel pins |
| fault | input | 8 | Per-channel fault flags |
| so_d | output | 1 | Serial data out value |
| so_en | output | 1 | Serial data out drive enable |
| gate | output | 8 | Channel gate enables |
| ol_en | output | 2 | Open-load detection enables (command bits 7..6) |

## Verification
A vector table sends frames of 0, 7, 8, 9 and 16 bits under different pin masks, with mode low and high. Each command is chosen so that the AND with the pins shows a different result from the command alone or the pins alone, which separates the two gating paths. The table also mixes frame lengths so that a discarded frame leaves a known earlier command visible. Distinct fault patterns in each frame check the returned bit order and the zero fill after eight bits. Directed tests then cover the reset state, a fault change after selection, and a command latched in limp-home mode that takes effect after release.

// File: rtl/oct_switch_ctrl.sv
module oct_switch_ctrl #(
  parameter int SYNC  = 2,
  parameter int FRAME = 8,
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       si,
  input  logic       mode,
  input  logic [7:0] par_in,
  input  logic [7:0] fault,
  output logic       so_d,
  output logic       so_en,
  output logic [7:0] gate,
  output logic [1:0] ol_en
);
  localparam logic [CNT_W-1:0] LEN_A = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] LEN_B = CNT_W'(2*FRAME);
  localparam logic [CNT_W-1:0] CMAX  = '1;

  logic [SYNC-1:0]  cs_q, ck_q, si_q;
  logic             cs_d, ck_d;
  logic [FRAME-1:0] sh_in, sh_out, cmd;
  logic [CNT_W-1:0] cnt;

  wire cs_s = cs_q[SYNC-1];
  wire ck_s = ck_q[SYNC-1];
  wire si_s = si_q[SYNC-1];

  wire cs_fall = cs_d & ~cs_s;
  wire cs_rise = ~cs_d & cs_s;
  wire ck_rise = ~ck_d & ck_s & ~cs_s;
  wire ck_fall = ck_d & ~ck_s & ~cs_s;
  wire len_ok  = (cnt == LEN_A) || (cnt == LEN_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '1; ck_q <= '0; si_q <= '0;
      cs_d <= 1'b1; ck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[SYNC-2:0], cs_n};
      ck_q <= {ck_q[SYNC-2:0], sclk};
      si_q <= {si_q[SYNC-2:0], si};
      cs_d <= cs_s;
      ck_d <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_in  <= '0;
      sh_out <= '0;
      cnt    <= '0;
      cmd    <= '0;
    end else begin
      if (cs_fall) begin
        sh_out <= fault;
        cnt    <= '0;
      end else begin
        if (ck_rise) begin
          sh_in <= {sh_in[FRAME-2:0], si_s};
          if (cnt != CMAX) cnt <= cnt + 1'b1;
        end
        if (ck_fall) sh_out <= {sh_out[FRAME-2:0], 1'b0};
      end
      if (cs_rise && len_ok) cmd <= sh_in;
    end
  end

  assign so_en = ~cs_s & ~mode;
  assign so_d  = so_en & sh_out[FRAME-1];
  assign gate  = mode ? {2'b00, par_in[5:0]}
                      : {par_in[7:6], cmd[5:0] & par_in[5:0]};
  assign ol_en = cmd[7:6];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cmd == '0 && ol_en == 2'b00));
  // R2
  frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && len_ok) |=> cmd == $past(sh_in));
  // R4
  bad_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !len_ok) |=> $stable(cmd));
  // R5
  pin_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> (gate[5:0] & ~par_in[5:0]) == 6'b0);
  // R6
  limp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> gate[7:6] == 2'b00);
  // R8
  so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_en);
  // R9
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sh_out == $past(fault));
endmodule

// File: tb/oct_switch_ctrl_tb.sv
module oct_switch_ctrl_tb;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, si = 0, mode = 0;
  logic [7:0] par_in = 8'hFF, fault = 8'h00;
  logic so_d, so_en;
  logic [7:0] gate;
  logic [1:0] ol_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  oct_switch_ctrl u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .si(si), .mode(mode), .par_in(par_in), .fault(fault), .so_d(so_d),
    .so_en(so_en), .gate(gate), .ol_en(ol_en));

  typedef struct packed {
    logic md; logic [7:0] par; logic [15:0] dat; logic [4:0] len;
    logic [7:0] flt; logic [7:0] eg; logic [1:0] eo;
  } vec_t;

  localparam vec_t TV [8] = '{
    '{1'b0, 8'hFF, 16'h00A5, 5'd8,  8'h81, 8'hE5, 2'b10},
    '{1'b0, 8'h0F, 16'h003C, 5'd8,  8'h5A, 8'h0C, 2'b00},
    '{1'b0, 8'hF0, 16'h12FF, 5'd16, 8'hFF, 8'hF0, 2'b11},
    '{1'b0, 8'hFF, 16'h0055, 5'd7,  8'h00, 8'hFF, 2'b11},
    '{1'b1, 8'hAA, 16'h0001, 5'd8,  8'h3C, 8'h2A, 2'b00},
    '{1'b0, 8'hFF, 16'h0000, 5'd0,  8'h96, 8'hC1, 2'b00},
    '{1'b0, 8'hC3, 16'h0000, 5'd9,  8'h01, 8'hC1, 2'b00},
    '{1'b0, 8'hFF, 16'hABC0, 5'd16, 8'hE7, 8'hC0, 2'b11}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] dat, input int len, input logic [7:0] flt,
                       input bit md, input bit late_flt);
    cs_n = 0;
    tick(4);
    chk(so_en == !md, "R8 so_en during frame", so_en, !md);
    if (late_flt) fault = ~flt;
    for (int k = 0; k < len; k++) begin
      si = dat[len-1-k];
      tick(4);
      if (!md) begin
        logic eb;
        eb = (k < 8) ? flt[7-k] : 1'b0;
        chk(so_d == eb, late_flt ? "R10 fault held" : "R9 so bit", so_d, eb);
      end
      sclk = 1; tick(4);
      sclk = 0;
    end
    tick(4);
    cs_n = 1;
    tick(6);
    chk(so_en == 0, "R8 so_en idle", so_en, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(3);
    // R1 reset state
    chk(gate == 8'hC0, "R1 gate", gate, 8'hC0);
    chk(ol_en == 0, "R1 ol_en", ol_en, 0);
    chk(so_en == 0, "R1 so_en", so_en, 0);

    // R2 R3 R4 R5 R6 R7 table
    for (int v = 0; v < 8; v++) begin
      mode = TV[v].md; par_in = TV[v].par; fault = TV[v].flt;
      tick(2);
      frame(TV[v].dat, TV[v].len, TV[v].flt, TV[v].md, 1'b0);
      chk(gate == TV[v].eg, "R2/R3/R4/R5/R6 gate", gate, TV[v].eg);
      chk(ol_en == TV[v].eo, "R2 ol_en", ol_en, TV[v].eo);
    end

    // R10 fault changes after selection
    mode = 0; par_in = 8'hFF; fault = 8'hA5;
    tick(2);
    frame(16'h003F, 8, 8'hA5, 1'b0, 1'b1);
    chk(gate == 8'hFF, "R5 gate all on", gate, 8'hFF);

    // R6 mode overrides command at once
    mode = 1; par_in = 8'h15;
    tick(2);
    chk(gate == 8'h15, "R6 limp gate", gate, 8'h15);
    chk(so_en == 0, "R8 mode releases so", so_en, 0);

    // R7 frame latched in limp mode, visible after release
    frame(16'h0012, 8, 8'h00, 1'b1, 1'b0);
    chk(gate == 8'h15, "R7 still limp", gate, 8'h15);
    mode = 0; par_in = 8'hFF;
    tick(2);
    chk(gate == 8'hD2, "R7 latched in limp", gate, 8'hD2);

    // R1 reset again clears command
    rst_n = 0; tick(2); rst_n = 1; tick(3);
    chk(gate == 8'hC0, "R1 re-reset gate", gate, 8'hC0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule